// File: doc/BRIEF.md
# Capture/Reload Timer with PWM

A 16-bit timer/counter peripheral for a microcontroller subsystem. It holds a running count, a capture/reload value and a compare value, all written through a simple write port and read back through a combinational read mux. A control word chooses between three counting behaviours. In edge-capture mode the counter free-runs and latches its value on a rising edge of an external pin. In reload-up mode it counts up and restarts from the reload value after the top. In up/down mode the external pin chooses the direction.

Counting advances only on cycles where an externally prescaled count enable is high and the run bit is set. A pulse-width output is set and cleared by compare matches and reload events, under a two-bit mode field. A separate clock output toggles on every reload or wrap. A sticky interrupt flag records each reload or wrap.

Register select codes: 0 is the control word, 1 the count, 2 the capture/reload value and 3 the compare value. Control bits: 0 is capture mode, 2 is run, 4 is up/down enable, 5 is clock output enable, 7 is the interrupt flag, and 12:11 is the pulse mode. All other control bits read 0.

Top module: `crtimer`

## Requirements
- R1: After reset all four registers read 0 and pwm_o, clk_o and irq_o are 0.
- R2: A write stores wr_data into the register chosen by wr_sel (0 control, 1 count, 2 reload, 3 compare). Control readback shows only bits 0, 2, 4, 5, 11 and 12 as written, and bit 7 as the flag. A count write takes priority over counting in the same cycle.
- R3: The count holds whenever the run bit (control bit 2) or tick is 0.
- R4: In reload-up mode (control bit 0 = 0, bit 4 = 0), an advance at FFFFh loads the reload value and sets the flag. Otherwise an advance increments the count.
- R5: In up/down mode (bit 4 = 1, bit 0 = 0), ext_pin = 1 counts up and loads the reload value after FFFFh. ext_pin = 0 counts down, loads FFFFh on an advance where the count equals the reload value, and sets the flag on that load.
- R6: In capture mode (bit 0 = 1), the counter increments and wraps from FFFFh to 0, setting the flag, regardless of bit 4. While run is set, a rising edge of ext_pin copies the current count into the reload register. Edges of ext_pin in other modes change nothing in that register.
- R7: The flag (control bit 7, also irq_o) is sticky. A control write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it. A reload or wrap in the same cycle as a clearing write leaves the flag set.
- R8: Pulse mode 01 sets pwm_o on a compare match and clears it on a reload. Mode 10 does the reverse. The reload action wins when both fall in the same advance. With reload value R and compare C in reload-up mode, mode 01 keeps pwm_o high for FFFFh - C of the 10000h - R cycles of each period.
- R9: Pulse mode 11 toggles pwm_o on each compare match, and reloads leave it alone. Mode 00 holds pwm_o at 0.
- R10: With control bit 5 set, clk_o toggles on every reload or wrap. With bit 5 clear, clk_o is 0.
- R11: A capture edge in the same cycle as a wrap from FFFFh captures FFFFh, leaves the count at 0 and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| ext_pin | input | 1 | Capture edge source or count direction |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | W | Selected register value |
| pwm_o | output | 1 | Pulse-width output |
| clk_o | output | 1 | Toggle-per-reload clock output |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
Two pairs of functions can fall in the same cycle, and both are provoked on purpose. In the first, a capture edge on ext_pin arrives on the advance that wraps the counter from FFFFh. The bench raises the pin on the cycle after writing FFFFh into the count, then expects a captured value of FFFFh, a count of 0 and a raised flag. In the second, a clearing control write lands on the same edge as a reload. The flag must survive that cycle and then clear on a later write that has no event. The compare sweep also drives the compare value to FFFFh, so the match and the reload coincide, and the duty measured over one period must show the reload action winning.

// File: rtl/crtimer.sv
module crtimer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ext_pin,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         pwm_o,
  output logic         clk_o,
  output logic         irq_o
);
  localparam int B_CAP = 0;
  localparam int B_RUN = 2;
  localparam int B_UD  = 4;
  localparam int B_CKO = 5;
  localparam int B_FLG = 7;
  localparam int B_PM  = 11;
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt, rld, cmp;
  logic         cap_m, run, ud_en, cko_en, flag;
  logic [1:0]   pm;
  logic         ext_q, pwm_q, clk_q;

  wire wr_ctl = wr_en && wr_sel == 2'd0;
  wire wr_cnt = wr_en && wr_sel == 2'd1;
  wire wr_rld = wr_en && wr_sel == 2'd2;
  wire wr_cmp = wr_en && wr_sel == 2'd3;

  wire adv     = run & tick;
  wire ud      = ud_en & ~cap_m;
  wire up      = ~ud | ext_pin;
  wire at_top  = cnt == TOP;
  wire wrap_ev = adv & cap_m & at_top;
  wire rld_ev  = adv & ~cap_m & (up ? at_top : (cnt == rld));
  wire any_ev  = wrap_ev | rld_ev;
  wire match   = adv & (cnt == cmp);
  wire cap_ev  = cap_m & run & ext_pin & ~ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (wr_cnt) cnt <= wr_data;
    else if (rld_ev) cnt <= up ? rld : TOP;
    else if (adv) cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rld <= '0;
    else if (wr_rld) rld <= wr_data;
    else if (cap_ev) rld <= cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmp <= '0;
    else if (wr_cmp) cmp <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_m <= 1'b0; run <= 1'b0; ud_en <= 1'b0; cko_en <= 1'b0; pm <= 2'b00;
    end else if (wr_ctl) begin
      cap_m  <= wr_data[B_CAP];
      run    <= wr_data[B_RUN];
      ud_en  <= wr_data[B_UD];
      cko_en <= wr_data[B_CKO];
      pm     <= wr_data[B_PM+1:B_PM];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else if (any_ev) flag <= 1'b1;
    else if (wr_ctl && !wr_data[B_FLG]) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else ext_q <= ext_pin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_q <= 1'b0;
    else begin
      unique case (pm)
        2'b00: pwm_q <= 1'b0;
        2'b01: if (any_ev) pwm_q <= 1'b0; else if (match) pwm_q <= 1'b1;
        2'b10: if (any_ev) pwm_q <= 1'b1; else if (match) pwm_q <= 1'b0;
        default: if (match) pwm_q <= ~pwm_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cko_en) clk_q <= 1'b0;
    else if (any_ev) clk_q <= ~clk_q;
  end

  logic [W-1:0] ctl_rd;
  always_comb begin
    ctl_rd = '0;
    ctl_rd[B_CAP] = cap_m;
    ctl_rd[B_RUN] = run;
    ctl_rd[B_UD]  = ud_en;
    ctl_rd[B_CKO] = cko_en;
    ctl_rd[B_FLG] = flag;
    ctl_rd[B_PM+1:B_PM] = pm;
  end

  always_comb begin
    unique case (rd_sel)
      2'd0: rd_data = ctl_rd;
      2'd1: rd_data = cnt;
      2'd2: rd_data = rld;
      default: rd_data = cmp;
    endcase
  end

  assign pwm_o = pwm_q;
  assign clk_o = clk_q;
  assign irq_o = flag;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && tick) && !wr_cnt) |=> cnt == $past(cnt));

  a_r4_up_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cap_m && !ud_en && at_top && !wr_cnt) |=> (cnt == $past(rld)) && irq_o);

  a_r5_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cap_m && ud_en && !ext_pin && cnt == rld && !wr_cnt) |=> cnt == TOP);

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_m && run && ext_pin && !ext_q && !wr_rld) |=> rld == $past(cnt));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(wr_ctl && !wr_data[B_FLG])) |=> irq_o);

  a_r8_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pm == 2'b01 && rld_ev) |=> !pwm_o);

  a_r10_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cko_en && !wr_ctl) |=> !clk_o);
endmodule

// File: tb/crtimer_bench.sv
module crtimer_bench;
  logic clk = 0, rst_n = 0, tick = 0, ext_pin = 0, wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic pwm_o, clk_o, irq_o;
  int checks = 0, errors = 0;

  crtimer #(.W(16)) u_crtimer (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] s, output logic [15:0] v);
    rd_sel = s; #0.5; v = rd_data;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [15:0] v;
  int hi;

  initial begin
    fork
      begin
        cyc(100000);
        errors++; checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    cyc(3); @(negedge clk); rst_n = 1;
    // R1
    for (int s = 0; s < 4; s++) begin rd(s[1:0], v); chk("R1 reg", v, 16'h0); end
    chk("R1 outs", {13'd0, pwm_o, clk_o, irq_o}, 16'h0);

    // R2
    wr(0, 16'hFFFF); rd(0, v); chk("R2 ctl", v, 16'h1835);
    wr(0, 16'h0000);
    wr(1, 16'h1234); rd(1, v); chk("R2 cnt", v, 16'h1234);
    wr(2, 16'hABCD); rd(2, v); chk("R2 rld", v, 16'hABCD);
    wr(3, 16'h5A5A); rd(3, v); chk("R2 cmp", v, 16'h5A5A);

    // R3
    wr(1, 16'h0040); wr(0, 16'h0004); cyc(5); rd(1, v); chk("R3 tick low", v, 16'h0040);
    wr(0, 16'h0000); tick = 1; cyc(5); rd(1, v); chk("R3 run off", v, 16'h0040);
    tick = 0;

    // R4
    wr(2, 16'h0100); wr(1, 16'hFFFD); wr(0, 16'h0004);
    tick = 1; cyc(2); rd(1, v); chk("R4 top", v, 16'hFFFF); chk("R4 no flag", irq_o, 0);
    cyc(1); rd(1, v); chk("R4 reload", v, 16'h0100); chk("R4 flag", irq_o, 1);
    tick = 0;

    // R7
    wr(0, 16'h0084); chk("R7 keep", irq_o, 1);
    wr(0, 16'h0004); chk("R7 clear", irq_o, 0);
    wr(1, 16'hFFFF);
    @(negedge clk); tick = 1; wr_en = 1; wr_sel = 0; wr_data = 16'h0004;
    @(negedge clk); wr_en = 0; tick = 0;
    chk("R7 event beats clear", irq_o, 1); rd(1, v); chk("R7 reload same", v, 16'h0100);
    wr(0, 16'h0004); chk("R7 clear after", irq_o, 0);

    // R5
    wr(0, 0); wr(2, 16'h0010); wr(1, 16'h0014); ext_pin = 0; wr(0, 16'h0014);
    tick = 1;
    for (int i = 1; i <= 6; i++) begin
      logic [15:0] e;
      e = (i <= 4) ? 16'(16'h0014 - i) : 16'(16'hFFFF - (i - 5));
      cyc(1); rd(1, v); chk("R5 down", v, e);
    end
    chk("R5 flag", irq_o, 1);
    ext_pin = 1; cyc(1); rd(1, v); chk("R5 up", v, 16'hFFFF);
    cyc(1); rd(1, v); chk("R5 up reload", v, 16'h0010);
    rd(2, v); chk("R6 no capture in reload", v, 16'h0010);
    tick = 0; ext_pin = 0; cyc(1);

    // R6
    wr(0, 0); wr(2, 0); wr(0, 16'h0015); tick = 1;
    for (int n = 0; n < 16; n++) begin
      wr(1, 16'h0100); cyc(n);
      ext_pin = 1; cyc(1);
      rd(2, v); chk("R6 capture", v, 16'(16'h0100 + n));
      rd(1, v); chk("R6 counts up", v, 16'(16'h0100 + n + 1));
      ext_pin = 0; cyc(1);
    end
    tick = 0;

    // R11
    wr(0, 16'h0015); wr(1, 16'hFFFF);
    @(negedge clk); ext_pin = 1; tick = 1;
    @(negedge clk); tick = 0;
    rd(2, v); chk("R11 capture top", v, 16'hFFFF);
    rd(1, v); chk("R11 wrapped", v, 16'h0000);
    chk("R11 flag", irq_o, 1);
    ext_pin = 0; wr(0, 0);

    // R8
    wr(2, 16'hFFF0);
    for (int m = 1; m <= 2; m++)
      for (int c = 16'hFFF0; c <= 16'hFFFF; c++) begin
        int e;
        wr(3, 16'(c)); wr(1, 16'hFFF0); wr(0, 16'(m << 11) | 16'h0004);
        tick = 1; cyc(32); hi = 0;
        for (int k = 0; k < 16; k++) begin cyc(1); hi += pwm_o; end
        tick = 0; wr(0, 0);
        e = (m == 1) ? (16'hFFFF - c) : (16 - (16'hFFFF - c));
        chk("R8 duty", 16'(hi), 16'(e));
      end

    // R9
    wr(3, 16'hFFF8); wr(1, 16'hFFF0); wr(0, 16'h1804);
    tick = 1; cyc(8); hi = 0;
    for (int k = 0; k < 32; k++) begin cyc(1); hi += pwm_o; end
    chk("R9 toggle duty", 16'(hi), 16);
    tick = 0; wr(0, 0); chk("R9 mode 00 low", pwm_o, 0);

    // R10
    wr(1, 16'hFFF0); wr(0, 16'h0024); tick = 1; cyc(8); hi = 0;
    begin
      int p = 0;
      for (int k = 0; k < 32; k++) begin cyc(1); hi += clk_o; p += pwm_o; end
      chk("R10 clk duty", 16'(hi), 16);
      chk("R10 pwm idle", 16'(p), 0);
    end
    wr(0, 16'h0004); hi = 0;
    for (int k = 0; k < 40; k++) begin cyc(1); hi += clk_o; end
    chk("R10 clk off", 16'(hi), 0);
    tick = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule